// File: doc/BRIEF.md
# Integer Multiply-Accumulate Unit

This block is the multiply stage of a processor datapath. It takes two 32-bit register operands and runs one of six integer multiply operations, chosen by a 3-bit opcode. The short forms return the low word of the product, with or without a 32-bit addend. The long forms return the whole 64-bit product as a high and a low word, signed or unsigned, with or without a 64-bit addend formed from two accumulator words.

A one-cycle start strobe launches an operation. Two cycles later the unit raises a one-cycle done pulse with the result words. When the flag-update input was set for that operation, the negative and zero flags are also refreshed. Results and flags keep their values between completions. A new operation may start on every cycle, and each one completes in issue order. A parameter selects between a direct signed multiplier and a sign-magnitude multiplier built from four half-width partial products.

Top module: `imac_unit`

## Requirements
- R1: Opcode 000 returns the low 32 bits of src_a*src_b on result_lo, and result_hi is 0.
- R2: Opcode 001 returns (low 32 bits of src_a*src_b) + acc_lo modulo 2^32 on result_lo. result_hi is 0 and acc_hi is ignored.
- R3: Opcode 100 returns the unsigned 64-bit product, with bits 63:32 on result_hi and bits 31:0 on result_lo.
- R4: Opcode 110 returns the two's-complement signed 64-bit product in the same word split. This holds for both multiplier variants.
- R5: Opcode 101 returns {acc_hi,acc_lo} plus the unsigned product, modulo 2^64, and carries from the low word into the high word.
- R6: Opcode 111 returns {acc_hi,acc_lo} plus the signed product, modulo 2^64.
- R7: Opcodes 010 and 011 return zero on both words and leave both flags unchanged. done still pulses.
- R8: For opcodes 000 and 001 with set_flags=1, flag_n becomes result_lo bit 31 and flag_z becomes 1 exactly when result_lo is zero.
- R9: For opcodes 1xx with set_flags=1, flag_n becomes result_hi bit 31 and flag_z becomes 1 exactly when all 64 result bits are zero.
- R10: With set_flags=0, both flags keep their previous values.
- R11: done is high for exactly one cycle, in the second cycle after the clock edge that samples start high. Starts on consecutive cycles each produce their own done, in order.
- R12: result_hi, result_lo, flag_n and flag_z change only in a cycle where done is high.
- R13: After reset, done, both result words and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches an operation with the inputs sampled at this edge |
| op | input | 3 | Operation code (see R1 to R7) |
| src_a | input | 32 | First multiplicand |
| src_b | input | 32 | Second multiplicand |
| acc_hi | input | 32 | Upper accumulator word (long accumulate only) |
| acc_lo | input | 32 | Lower accumulator word |
| set_flags | input | 1 | Update flags from this result |
| result_hi | output | 32 | Upper result word |
| result_lo | output | 32 | Lower result word |
| done | output | 1 | One-cycle completion pulse |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bound properties check on every cycle that done follows start by exactly two cycles and that outputs hold between completions. They also check that short and reserved forms leave the high word zero, that the low word of the plain multiply matches the operands, that flags follow the result width rule, and that flags hold when updates are off or the opcode is reserved. Only the bench scenarios show the long products and accumulations against an independent model. These include carry across the word boundary, the most-negative signed operands, and a 64-bit zero that a 32-bit test would miss. The bench also shows that both multiplier variants agree.

// File: rtl/imac_pkg.sv
package imac_pkg;
   typedef enum logic [2:0] {
      OP_MUL   = 3'b000,
      OP_MLA   = 3'b001,
      OP_RSV0  = 3'b010,
      OP_RSV1  = 3'b011,
      OP_UMULL = 3'b100,
      OP_UMLAL = 3'b101,
      OP_SMULL = 3'b110,
      OP_SMLAL = 3'b111
   } imac_op_e;

   typedef struct packed {
      logic wide;
      logic is_signed;
      logic accum;
      logic reserved;
   } imac_ctl_t;
endpackage

// File: rtl/imac_decode.sv
module imac_decode
   import imac_pkg::*;
(
   input  logic [2:0] op,
   output imac_ctl_t  ctl
);
   imac_op_e opv;

   always_comb begin
      opv = imac_op_e'(op);
      ctl = '0;
      unique case (opv)
         OP_MUL:   ctl = '{wide: 1'b0, is_signed: 1'b0, accum: 1'b0, reserved: 1'b0};
         OP_MLA:   ctl = '{wide: 1'b0, is_signed: 1'b0, accum: 1'b1, reserved: 1'b0};
         OP_RSV0,
         OP_RSV1:  ctl = '{wide: 1'b0, is_signed: 1'b0, accum: 1'b0, reserved: 1'b1};
         OP_UMULL: ctl = '{wide: 1'b1, is_signed: 1'b0, accum: 1'b0, reserved: 1'b0};
         OP_UMLAL: ctl = '{wide: 1'b1, is_signed: 1'b0, accum: 1'b1, reserved: 1'b0};
         OP_SMULL: ctl = '{wide: 1'b1, is_signed: 1'b1, accum: 1'b0, reserved: 1'b0};
         OP_SMLAL: ctl = '{wide: 1'b1, is_signed: 1'b1, accum: 1'b1, reserved: 1'b0};
         default:  ctl = '0;
      endcase
   end
endmodule

// File: rtl/imac_mult.sv
module imac_mult #(
   parameter int W          = 32,
   parameter bit SPLIT_MULT = 1'b0
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           sgn,
   output logic [2*W-1:0] prod
);
   localparam int PW = 2 * W;
   localparam int H  = W / 2;

   generate
      if (SPLIT_MULT) begin : g_split
         logic         neg_a, neg_b, neg_p;
         logic [W-1:0] ma, mb;
         logic [W-1:0] pp_ll, pp_lh, pp_hl, pp_hh;
         logic [PW-1:0] mag;

         always_comb begin
            neg_a = sgn & a[W-1];
            neg_b = sgn & b[W-1];
            neg_p = neg_a ^ neg_b;
            ma    = neg_a ? (~a + 1'b1) : a;
            mb    = neg_b ? (~b + 1'b1) : b;
            pp_ll = W'(ma[H-1:0]) * W'(mb[H-1:0]);
            pp_lh = W'(ma[H-1:0]) * W'(mb[W-1:H]);
            pp_hl = W'(ma[W-1:H]) * W'(mb[H-1:0]);
            pp_hh = W'(ma[W-1:H]) * W'(mb[W-1:H]);
            mag   = {{W{1'b0}}, pp_ll}
                  + ({{W{1'b0}}, pp_lh} << H)
                  + ({{W{1'b0}}, pp_hl} << H)
                  + {pp_hh, {W{1'b0}}};
            prod  = neg_p ? (~mag + 1'b1) : mag;
         end
      end else begin : g_direct
         logic signed [W:0]    ae, be;
         logic signed [PW+1:0] pf;

         always_comb begin
            ae   = {sgn & a[W-1], a};
            be   = {sgn & b[W-1], b};
            pf   = ae * be;
            prod = pf[PW-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/imac_accum.sv
module imac_accum
   import imac_pkg::*;
#(
   parameter int W = 32
) (
   input  imac_ctl_t      ctl,
   input  logic [2*W-1:0] prod,
   input  logic [W-1:0]   acc_hi,
   input  logic [W-1:0]   acc_lo,
   output logic [W-1:0]   res_hi,
   output logic [W-1:0]   res_lo,
   output logic           neg,
   output logic           zero
);
   localparam int PW = 2 * W;

   logic [PW-1:0] addend;
   logic [PW-1:0] sum_w;
   logic [W-1:0]  sum_s;

   always_comb begin
      addend = ctl.accum ? {acc_hi, acc_lo} : '0;
      sum_w  = prod + addend;
      sum_s  = prod[W-1:0] + addend[W-1:0];
      if (ctl.reserved) begin
         res_hi = '0;
         res_lo = '0;
      end else if (ctl.wide) begin
         res_hi = sum_w[PW-1:W];
         res_lo = sum_w[W-1:0];
      end else begin
         res_hi = '0;
         res_lo = sum_s;
      end
      neg  = ctl.wide ? res_hi[W-1] : res_lo[W-1];
      zero = ctl.wide ? ~|{res_hi, res_lo} : ~|res_lo;
   end
endmodule

// File: rtl/imac_unit.sv
module imac_unit
   import imac_pkg::*;
#(
   parameter int W          = 32,
   parameter bit SPLIT_MULT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [2:0]   op,
   input  logic [W-1:0] src_a,
   input  logic [W-1:0] src_b,
   input  logic [W-1:0] acc_hi,
   input  logic [W-1:0] acc_lo,
   input  logic         set_flags,
   output logic [W-1:0] result_hi,
   output logic [W-1:0] result_lo,
   output logic         done,
   output logic         flag_n,
   output logic         flag_z
);
   localparam int PW = 2 * W;

   generate
      if (W < 4 || (W % 2) != 0) begin : g_bad_width
         $error("imac_unit: W must be even and at least 4");
      end
   endgenerate

   imac_ctl_t     dec_ctl;
   logic [PW-1:0] mul_prod;

   imac_decode u_dec (
      .op  (op),
      .ctl (dec_ctl)
   );

   imac_mult #(.W(W), .SPLIT_MULT(SPLIT_MULT)) u_mul (
      .a    (src_a),
      .b    (src_b),
      .sgn  (dec_ctl.is_signed),
      .prod (mul_prod)
   );

   // stage 1: product and operation context
   logic          s1_valid;
   imac_ctl_t     s1_ctl;
   logic          s1_setf;
   logic [PW-1:0] s1_prod;
   logic [W-1:0]  s1_acc_hi, s1_acc_lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_ctl    <= '0;
         s1_setf   <= 1'b0;
         s1_prod   <= '0;
         s1_acc_hi <= '0;
         s1_acc_lo <= '0;
      end else begin
         s1_valid <= start;
         if (start) begin
            s1_ctl    <= dec_ctl;
            s1_setf   <= set_flags;
            s1_prod   <= mul_prod;
            s1_acc_hi <= acc_hi;
            s1_acc_lo <= acc_lo;
         end
      end
   end

   // stage 2: accumulate, flags, output hold
   logic [W-1:0] acc_res_hi, acc_res_lo;
   logic         acc_neg, acc_zero;

   imac_accum #(.W(W)) u_acc (
      .ctl    (s1_ctl),
      .prod   (s1_prod),
      .acc_hi (s1_acc_hi),
      .acc_lo (s1_acc_lo),
      .res_hi (acc_res_hi),
      .res_lo (acc_res_lo),
      .neg    (acc_neg),
      .zero   (acc_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done      <= 1'b0;
         result_hi <= '0;
         result_lo <= '0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
      end else begin
         done <= s1_valid;
         if (s1_valid) begin
            result_hi <= acc_res_hi;
            result_lo <= acc_res_lo;
            if (s1_setf && !s1_ctl.reserved) begin
               flag_n <= acc_neg;
               flag_z <= acc_zero;
            end
         end
      end
   end
endmodule

// File: rtl/imac_chk.sv
module imac_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [2:0]   op,
   input logic [W-1:0] src_a,
   input logic [W-1:0] src_b,
   input logic         set_flags,
   input logic [W-1:0] result_hi,
   input logic [W-1:0] result_lo,
   input logic         done,
   input logic         flag_n,
   input logic         flag_z
);
   logic         c1_start, c2_start;
   logic [2:0]   c1_op, c2_op;
   logic         c1_setf, c2_setf;
   logic [W-1:0] c1_a, c2_a, c1_b, c2_b;
   logic [W-1:0] low_exp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c1_start <= 1'b0;  c2_start <= 1'b0;
         c1_op    <= '0;    c2_op    <= '0;
         c1_setf  <= 1'b0;  c2_setf  <= 1'b0;
         c1_a     <= '0;    c2_a     <= '0;
         c1_b     <= '0;    c2_b     <= '0;
      end else begin
         c1_start <= start;     c2_start <= c1_start;
         c1_op    <= op;        c2_op    <= c1_op;
         c1_setf  <= set_flags; c2_setf  <= c1_setf;
         c1_a     <= src_a;     c2_a     <= c1_a;
         c1_b     <= src_b;     c2_b     <= c1_b;
      end
   end

   assign low_exp = c2_a * c2_b;

   assert_done_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done == c2_start);

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result_hi) && $stable(result_lo) && $stable(flag_n) && $stable(flag_z)));

   assert_short_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !c2_op[2]) |-> (result_hi == '0));

   assert_mul_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && c2_op == 3'b000) |-> (result_lo == low_exp));

   assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && c2_op[2:1] == 2'b01) |-> (result_lo == '0 && $stable(flag_n) && $stable(flag_z)));

   assert_noflag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !c2_setf) |-> ($stable(flag_n) && $stable(flag_z)));

   assert_flag_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && c2_setf && c2_op[2:1] == 2'b00)
         |-> (flag_n == result_lo[W-1] && flag_z == (result_lo == '0)));

   assert_flag_long_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && c2_setf && c2_op[2])
         |-> (flag_n == result_hi[W-1] && flag_z == ({result_hi, result_lo} == '0)));
endmodule

bind imac_unit imac_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .op        (op),
   .src_a     (src_a),
   .src_b     (src_b),
   .set_flags (set_flags),
   .result_hi (result_hi),
   .result_lo (result_lo),
   .done      (done),
   .flag_n    (flag_n),
   .flag_z    (flag_z)
);

// File: tb/tb_imac_unit.sv
module tb_imac_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = '0;
   logic [31:0] src_a = '0, src_b = '0, acc_hi = '0, acc_lo = '0;
   logic        set_flags = 1'b0;
   logic [31:0] result_hi, result_lo, s_hi, s_lo;
   logic        done, flag_n, flag_z, s_done, s_n, s_z;

   always #5 clk = ~clk;

   imac_unit #(.W(32), .SPLIT_MULT(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .src_a(src_a), .src_b(src_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
      .set_flags(set_flags), .result_hi(result_hi), .result_lo(result_lo),
      .done(done), .flag_n(flag_n), .flag_z(flag_z));

   imac_unit #(.W(32), .SPLIT_MULT(1'b1)) dut_split (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .src_a(src_a), .src_b(src_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
      .set_flags(set_flags), .result_hi(s_hi), .result_lo(s_lo),
      .done(s_done), .flag_n(s_n), .flag_z(s_z));

   typedef struct {
      logic [63:0] res;
      logic        n, z;
      string       rtag, ftag;
      int          due;
   } exp_t;

   exp_t q[$];
   int   checks = 0, errors = 0, cyc = 0, hold_viol = 0;
   logic m_n = 1'b0, m_z = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // driver: called just after a falling edge
   task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] ah, input logic [31:0] al, input logic sf);
      exp_t        e;
      logic [63:0] pu, ps, acc64;
      pu    = {32'h0, a} * {32'h0, b};
      ps    = {{32{a[31]}}, a} * {{32{b[31]}}, b};
      acc64 = {ah, al};
      case (o)
         3'b000:  begin e.res = {32'h0, pu[31:0]};       e.rtag = "R1"; end
         3'b001:  begin e.res = {32'h0, pu[31:0] + al};  e.rtag = "R2"; end
         3'b100:  begin e.res = pu;                      e.rtag = "R3"; end
         3'b101:  begin e.res = pu + acc64;              e.rtag = "R5"; end
         3'b110:  begin e.res = ps;                      e.rtag = "R4"; end
         3'b111:  begin e.res = ps + acc64;              e.rtag = "R6"; end
         default: begin e.res = 64'h0;                   e.rtag = "R7"; end
      endcase
      if (o[2:1] == 2'b01)      e.ftag = "R7";
      else if (!sf)             e.ftag = "R10";
      else if (o[2]) begin
         e.ftag = "R9";  m_n = e.res[63]; m_z = (e.res == 64'h0);
      end else begin
         e.ftag = "R8";  m_n = e.res[31]; m_z = (e.res[31:0] == 32'h0);
      end
      e.n = m_n; e.z = m_z;
      op = o; src_a = a; src_b = b; acc_hi = ah; acc_lo = al; set_flags = sf;
      start = 1'b1;
      e.due = cyc + 2;
      q.push_back(e);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops expected items as results appear
   logic [65:0] snap = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!done && snap != {result_hi, result_lo, flag_n, flag_z}) hold_viol++;
         if (done) begin
            if (q.size() == 0) begin
               chk(1'b0, "R11 unexpected done", 64'(cyc), 64'h0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk({result_hi, result_lo} == e.res, e.rtag, {result_hi, result_lo}, e.res);
               chk({flag_n, flag_z} == {e.n, e.z}, e.ftag, 64'({flag_n, flag_z}), 64'({e.n, e.z}));
               chk(cyc == e.due, "R11 done cycle", 64'(cyc), 64'(e.due));
               chk({s_hi, s_lo, s_n, s_z, s_done} == {result_hi, result_lo, flag_n, flag_z, done},
                   "R4 split variant", {s_hi, s_lo}, {result_hi, result_lo});
            end
         end
      end
      snap = {result_hi, result_lo, flag_n, flag_z};
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", 64'(cyc), 64'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R13 reset state
      chk(done == 1'b0, "R13 done", 64'(done), 64'h0);
      chk({result_hi, result_lo} == 64'h0, "R13 result", {result_hi, result_lo}, 64'h0);
      chk({flag_n, flag_z} == 2'b00, "R13 flags", 64'({flag_n, flag_z}), 64'h0);

      issue(3'b000, 32'd7, 32'd6, 32'h1234, 32'h5678, 1'b1);           // R1
      idle(3);
      issue(3'b000, 32'hFFFF_FFFF, 32'd2, 32'h0, 32'h0, 1'b1);         // R1 R8 negative
      idle(3);
      issue(3'b001, 32'd3, 32'd5, 32'hDEAD_BEEF, 32'hFFFF_FFF1, 1'b1); // R2 wrap to zero, R8 zero
      idle(3);
      issue(3'b000, 32'h8000_0000, 32'd1, 32'h0, 32'h0, 1'b0);         // R10 flags kept
      idle(3);
      issue(3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1); // R3 R9
      idle(3);
      issue(3'b110, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1); // R4 -1*-1
      idle(3);
      issue(3'b110, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, 1'b1); // R4 most negative
      idle(3);
      issue(3'b110, 32'hFFFF_FFFD, 32'd5, 32'h0, 32'h0, 1'b1);         // R4 negative result
      idle(3);
      issue(3'b101, 32'hFFFF_FFFF, 32'd1, 32'h0, 32'h1, 1'b1);         // R5 carry into hi
      idle(3);
      issue(3'b111, 32'hFFFF_FFFF, 32'd1, 32'h0, 32'h1, 1'b1);         // R6 sum zero, R9
      idle(3);
      issue(3'b101, 32'h0, 32'd9, 32'h1, 32'h0, 1'b1);                 // R9 low zero, hi not
      idle(3);
      issue(3'b010, 32'd4, 32'd4, 32'h1, 32'h1, 1'b1);                 // R7
      idle(3);
      issue(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1); // R7
      idle(3);
      // R11 back-to-back starts
      issue(3'b100, 32'd10, 32'd20, 32'h0, 32'h0, 1'b1);
      issue(3'b111, 32'hFFFF_FFF0, 32'd3, 32'h7, 32'h9, 1'b1);
      issue(3'b001, 32'd2, 32'd2, 32'hFFFF, 32'd1, 1'b0);
      idle(4);
      for (int i = 0; i < 60; i++) begin
         issue(3'($urandom), $urandom, $urandom, $urandom, $urandom, 1'($urandom));
         if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
      end
      idle(6);
      chk(q.size() == 0, "R11 pending results", 64'(q.size()), 64'h0);
      chk(hold_viol == 0, "R12 outputs changed without done", 64'(hold_viol), 64'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule